// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block counts hardware events for performance analysis. Event sources outside the block present one bit vector per event group. Each counter picks one group and a bitmask within that group. On every clock it adds a qualified amount to its value. That amount is either the number of selected events that are active, or a single count decided by a threshold compare, an inverted compare or a rising-edge detect.

The host reaches every register through a single 64-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. The first `NUM_FIXED` counters are fixed-function: their group and mask are constants that software cannot change. The other counters are fully configurable.

A counter that wraps keeps its wrapped low bits and sets its overflow flag. It can optionally raise the level interrupt, and it can optionally freeze every counter in the same edge. Software can still write all values and configurations while the counters are frozen.

Top module: `pmu_unit`

## Requirements
- R1: After a synchronous reset, all counter values are zero, the overflow and freeze registers are zero, `irq_o` is low and every enable is clear. The capability word at offset 0x0 reads as follows:
  - bits [5:0] hold NUM_CNT-1;
  - bits [15:8] hold CNT_W;
  - bits [24:20] hold NUM_GRP-1;
  - bits 48, 49 and 50 are set (writable while frozen, freeze supported, interrupt supported).
- R2: The configuration word at 0x200+8·n has this layout: [1:0] type, 8 enable, 9 interrupt-on-overflow, 10 freeze-on-overflow, 11 edge, 12 invert, [23:16] threshold, [55:24] event mask, [63:59] group index. The type field is read-only and reads 1 on fixed counters and 2 on configurable counters. On a fixed counter n, the mask reads all ones over EVT_W and the group reads n mod NUM_GRP, whatever software writes.
- R3: In raw mode (not inverted, threshold 0 or 1), an enabled counter that is not frozen adds the number of bits set in both its group's event vector and its mask. Group g occupies `evt_i[g*EVT_W +: EVT_W]`.
- R4: With a threshold above 1 and invert clear, the counter adds 1 on each cycle where the masked sum is at least the threshold.
- R5: With invert set, the counter adds 1 on each cycle where the masked sum is below the threshold. A threshold of 0 is treated as 1.
- R6: With edge set, the counter adds 1 only on a cycle where the qualified condition becomes true after being false in the previous cycle. In raw mode that condition is a non-zero sum.
- R7: The freeze register at 0x18 holds one bit per counter, and a set bit stops that counter. While frozen, counter values (0xC00+8·n) and configurations stay writable and read back what was written.
- R8: When an addition carries out of CNT_W bits, the counter keeps the wrapped low bits and its overflow bit at 0x10 is set in the same edge.
- R9: Writing a 1 to a bit of the overflow register clears that bit. Writing a 0 leaves it unchanged.
- R10: `irq_o` is high exactly while some counter has both its overflow bit and its interrupt-on-overflow enable set.
- R11: A wrap on a counter with freeze-on-overflow set sets all freeze bits in the same edge that sets its overflow bit. A wrap without that option leaves the freeze register unchanged.
- R12: The event capability entry at 0x100+8·g reads the group number g in bits [47:32] and the supported-event mask (EVT_W ones) in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the 64-bit register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| evt_i | input | NUM_GRP*EVT_W | Event vectors, one slice per group |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
A wrong event-group select or mask gate shows as a wrong counter value one edge after the stimulus. A broken qualifier (threshold, invert or edge history) shows as a difference of whole counts after a short event sequence.

A fault in the overflow path shows on the same edge as the wrap, at the following places:
- the overflow register;
- the freeze register, when freeze-on-overflow is set;
- `irq_o`.

A lost freeze bit shows as a counter value that keeps moving while frozen.

// File: rtl/pmu_pkg.sv
// Shared register offsets, field codes and the configuration record.
// Assumes 64-bit registers on 8-byte aligned byte addresses.
package pmu_pkg;
    localparam logic [11:0] OFS_CAP    = 12'h000;
    localparam logic [11:0] OFS_OVF    = 12'h010;
    localparam logic [11:0] OFS_FRZ    = 12'h018;
    localparam logic [3:0]  PAGE_EVCAP = 4'h1;
    localparam logic [3:0]  PAGE_CFG   = 4'h2;
    localparam logic [3:0]  PAGE_VAL   = 4'hC;
    localparam logic [1:0]  KIND_FIXED = 2'd1;
    localparam logic [1:0]  KIND_CONF  = 2'd2;

    typedef struct packed {
        logic [4:0]  grp;
        logic [31:0] mask;
        logic [7:0]  thr;
        logic        inv;
        logic        edg;
        logic        foe;
        logic        ioe;
        logic        en;
        logic [1:0]  kind;
    } cfg_t;

    // Split a written configuration word into its fields.
    function automatic cfg_t cfg_unpack(input logic [63:0] w);
        cfg_t c;
        c.grp  = w[63:59];
        c.mask = w[55:24];
        c.thr  = w[23:16];
        c.inv  = w[12];
        c.edg  = w[11];
        c.foe  = w[10];
        c.ioe  = w[9];
        c.en   = w[8];
        c.kind = w[1:0];
        return c;
    endfunction

    // Build the readable configuration word from its fields.
    function automatic logic [63:0] cfg_pack(input cfg_t c);
        logic [63:0] w;
        w        = '0;
        w[63:59] = c.grp;
        w[55:24] = c.mask;
        w[23:16] = c.thr;
        w[12]    = c.inv;
        w[11]    = c.edg;
        w[10]    = c.foe;
        w[9]     = c.ioe;
        w[8]     = c.en;
        w[1:0]   = c.kind;
        return w;
    endfunction
endpackage

// File: rtl/pmu_evq.sv
// Event qualifier: selects one group, masks it, sums the active bits and
// applies the threshold, invert and edge options to give the per-cycle
// increment. Assumes EVT_W <= 32 so the sum fits a 9-bit compare.
module pmu_evq #(
    parameter int EVT_W   = 8,
    parameter int NUM_GRP = 2,
    parameter int INC_W   = $clog2(EVT_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0]         mask,
    input  logic [4:0]               grp,
    input  logic [7:0]               thr,
    input  logic                     inv,
    input  logic                     edg,
    output logic [INC_W-1:0]         inc
);
    logic [EVT_W-1:0] sel;
    logic [INC_W-1:0] sum;
    logic [8:0]       sum9, eff_thr;
    logic             raw_mode, pass, level, level_q;

    // Pick the chosen group's vector; an index past the last group gives zero.
    always_comb begin
        sel = '0;
        for (int g = 0; g < NUM_GRP; g++)
            if (grp == 5'(g)) sel = evt_i[g*EVT_W +: EVT_W];
    end

    // Count the selected events that the mask lets through.
    always_comb begin
        sum = '0;
        for (int b = 0; b < EVT_W; b++)
            sum = sum + INC_W'(sel[b] & mask[b]);
    end

    // Threshold, invert and edge qualification.
    always_comb begin
        sum9     = 9'(sum);
        eff_thr  = (thr == 8'd0) ? 9'd1 : {1'b0, thr};
        raw_mode = !inv && (thr <= 8'd1);
        pass     = inv ? (sum9 < eff_thr) : (sum9 >= eff_thr);
        level    = raw_mode ? (sum != '0) : pass;
        if (edg)           inc = INC_W'(level && !level_q);
        else if (raw_mode) inc = sum;
        else               inc = INC_W'(pass);
    end

    // Remember last cycle's condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end
endmodule

// File: rtl/pmu_ctr.sv
// One counter slice: configuration register, qualifier and value register.
// A fixed counter holds a constant all-ones mask and group FIX_GRP.
// Assumes the top decodes the write strobes.
module pmu_ctr
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int EVT_W    = 8,
    parameter int NUM_GRP  = 2,
    parameter bit IS_FIXED = 1'b0,
    parameter int FIX_GRP  = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*EVT_W-1:0] evt_i,
    input  logic                     cfg_we,
    input  cfg_t                     cfg_in,
    input  logic                     val_we,
    input  logic [CNT_W-1:0]         val_in,
    input  logic                     frozen,
    output cfg_t                     cfg_o,
    output logic [CNT_W-1:0]         cnt_o,
    output logic                     wrap_o
);
    localparam int INC_W = $clog2(EVT_W + 1);

    logic             en_q, ioe_q, foe_q, edg_q, inv_q;
    logic [7:0]       thr_q;
    logic [EVT_W-1:0] mask_v;
    logic [4:0]       grp_v;
    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             carry, active;
    logic             unused_cfg;

    assign unused_cfg = ^{cfg_in.kind, cfg_in.mask, cfg_in.grp};

    // Writable qualifier and control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {en_q, ioe_q, foe_q, edg_q, inv_q} <= '0;
            thr_q <= '0;
        end else if (cfg_we) begin
            {en_q, ioe_q, foe_q, edg_q, inv_q} <=
                {cfg_in.en, cfg_in.ioe, cfg_in.foe, cfg_in.edg, cfg_in.inv};
            thr_q <= cfg_in.thr;
        end
    end

    generate
        if (IS_FIXED) begin : g_fixed
            assign mask_v = '1;
            assign grp_v  = 5'(FIX_GRP);
        end else begin : g_conf
            logic [EVT_W-1:0] mask_q;
            logic [4:0]       grp_q;
            // Software-chosen event mask and group.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q <= '0;
                    grp_q  <= '0;
                end else if (cfg_we) begin
                    mask_q <= cfg_in.mask[EVT_W-1:0];
                    grp_q  <= cfg_in.grp;
                end
            end
            assign mask_v = mask_q;
            assign grp_v  = grp_q;
        end
    endgenerate

    pmu_evq #(.EVT_W(EVT_W), .NUM_GRP(NUM_GRP)) u_evq (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask(mask_v), .grp(grp_v),
        .thr(thr_q), .inv(inv_q), .edg(edg_q), .inc(inc)
    );

    // Next value and carry out of the counter width.
    always_comb begin
        active          = en_q && !frozen && !val_we;
        {carry, cnt_nx} = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        wrap_o          = active && carry;
    end

    // Counter value: a software load wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (val_we) cnt_q <= val_in;
        else if (active) cnt_q <= cnt_nx;
    end

    // Readable view of the configuration.
    always_comb begin
        cfg_o      = '0;
        cfg_o.kind = IS_FIXED ? KIND_FIXED : KIND_CONF;
        cfg_o.en   = en_q;
        cfg_o.ioe  = ioe_q;
        cfg_o.foe  = foe_q;
        cfg_o.edg  = edg_q;
        cfg_o.inv  = inv_q;
        cfg_o.thr  = thr_q;
        cfg_o.mask[EVT_W-1:0] = mask_v;
        cfg_o.grp  = grp_v;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_unit.sv
// Top of the event counter unit: register decode, overflow and freeze
// registers, interrupt and read mux. Assumes NUM_CNT <= 32, NUM_GRP <= 32,
// EVT_W <= 32 and CNT_W <= 64.
module pmu_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int CNT_W     = 16,
    parameter int NUM_GRP   = 2,
    parameter int EVT_W     = 8,
    parameter int NUM_FIXED = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [11:0]              reg_addr,
    input  logic [63:0]              reg_wdata,
    output logic [63:0]              reg_rdata,
    input  logic [NUM_GRP*EVT_W-1:0] evt_i,
    output logic                     irq_o
);
    localparam logic [63:0] CAP_WORD =
        (64'd7 << 48) | (64'(NUM_GRP - 1) << 20) | (64'(CNT_W) << 8) | 64'(NUM_CNT - 1);

    cfg_t               cfg_in;
    cfg_t               cfg_rd [NUM_CNT];
    logic [CNT_W-1:0]   cnt_rd [NUM_CNT];
    logic [NUM_CNT-1:0] wrap, ioe_v, foe_v, ovf_q, frz_q;
    logic [4:0]         idx;
    logic               wr_ovf, wr_frz;
    logic               unused_wbits;

    assign cfg_in       = cfg_unpack(reg_wdata);
    assign idx          = reg_addr[7:3];
    assign wr_ovf       = reg_wr && (reg_addr == OFS_OVF);
    assign wr_frz       = reg_wr && (reg_addr == OFS_FRZ);
    assign unused_wbits = ^reg_wdata;

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
            logic cfg_we, val_we;
            assign cfg_we = reg_wr && (reg_addr == {PAGE_CFG, 8'(8*i)});
            assign val_we = reg_wr && (reg_addr == {PAGE_VAL, 8'(8*i)});
            pmu_ctr #(
                .CNT_W(CNT_W), .EVT_W(EVT_W), .NUM_GRP(NUM_GRP),
                .IS_FIXED(i < NUM_FIXED), .FIX_GRP(i % NUM_GRP)
            ) u_ctr (
                .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
                .cfg_we(cfg_we), .cfg_in(cfg_in),
                .val_we(val_we), .val_in(reg_wdata[CNT_W-1:0]),
                .frozen(frz_q[i]), .cfg_o(cfg_rd[i]), .cnt_o(cnt_rd[i]),
                .wrap_o(wrap[i])
            );
            assign ioe_v[i] = cfg_rd[i].ioe;
            assign foe_v[i] = cfg_rd[i].foe;
        end
    endgenerate

    // Overflow flags: set by a wrap, cleared by writing ones; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata[NUM_CNT-1:0] : '0)) | wrap;
    end

    // Freeze bits: a freezing wrap stops every counter, otherwise software sets them.
    always_ff @(posedge clk) begin
        if (!rst_n)                frz_q <= '0;
        else if (|(wrap & foe_v))  frz_q <= '1;
        else if (wr_frz)           frz_q <= reg_wdata[NUM_CNT-1:0];
    end

    assign irq_o = |(ovf_q & ioe_v);

    // Read mux by address page and index.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[2:0] == 3'd0) begin
            unique case (reg_addr[11:8])
                4'h0: begin
                    if (reg_addr == OFS_CAP)      reg_rdata = CAP_WORD;
                    else if (reg_addr == OFS_OVF) reg_rdata = 64'(ovf_q);
                    else if (reg_addr == OFS_FRZ) reg_rdata = 64'(frz_q);
                end
                PAGE_EVCAP: if (32'(idx) < NUM_GRP)
                    reg_rdata = (64'(idx) << 32) | 64'({EVT_W{1'b1}});
                PAGE_CFG:   if (32'(idx) < NUM_CNT) reg_rdata = cfg_pack(cfg_rd[idx]);
                PAGE_VAL:   if (32'(idx) < NUM_CNT) reg_rdata = 64'(cnt_rd[idx]);
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmu_unit_checker.sv
// Property checker for pmu_unit, attached with bind below.
// It observes the overflow, freeze and wrap state and the counter values.
module pmu_unit_checker #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [11:0]              reg_addr,
    input logic                     irq_o,
    input logic [NUM_CNT-1:0]       ovf_q,
    input logic [NUM_CNT-1:0]       frz_q,
    input logic [NUM_CNT-1:0]       wrap,
    input logic [NUM_CNT-1:0]       foe_v,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
    // Reset leaves no flag or freeze bit behind (R1).
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ovf_q == '0 && frz_q == '0 && !irq_o));

    // A wrap sets the overflow bit on the same edge (R8).
    assert_wrap_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((ovf_q & $past(wrap)) == $past(wrap)));

    // Overflow bits only leave through a write to the overflow register (R9).
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 12'h010) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // The interrupt never stands without an overflow flag (R10).
    assert_irq_has_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|ovf_q));

    // A freezing wrap freezes every counter on the next edge (R11).
    assert_freeze_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wrap & foe_v)) |=> (&frz_q));

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_hold
            // A frozen counter holds unless software loads it (R7).
            assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (frz_q[i] && !(reg_wr && reg_addr == {4'hC, 8'(8*i)}))
                |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
        end
    endgenerate
endmodule

bind pmu_unit pmu_unit_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .irq_o(irq_o), .ovf_q(ovf_q), .frz_q(frz_q), .wrap(wrap), .foe_v(foe_v),
    .cnt_flat({cnt_rd[3], cnt_rd[2], cnt_rd[1], cnt_rd[0]})
);

// File: tb/tb_pmu_unit.sv
// Directed bench for pmu_unit: one task per scenario, each checking its results.
module tb_pmu_unit;
    localparam int NUM_CNT = 4, CNT_W = 16, NUM_GRP = 2, EVT_W = 8;
    localparam logic [11:0] A_CAP = 12'h000, A_OVF = 12'h010, A_FRZ = 12'h018;

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic [15:0] evt_i = '0;
    logic        irq_o;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;

    pmu_unit #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NUM_GRP(NUM_GRP), .EVT_W(EVT_W),
               .NUM_FIXED(1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o));

    function automatic logic [11:0] a_cfg(input int n); return 12'h200 + 12'(8*n); endfunction
    function automatic logic [11:0] a_val(input int n); return 12'hC00 + 12'(8*n); endfunction

    function automatic logic [63:0] mk(input bit en, ioe, foe, edg, inv,
                                       input logic [7:0] thr, input logic [31:0] mask,
                                       input logic [4:0] grp);
        return (64'(grp) << 59) | (64'(mask) << 24) | (64'(thr) << 16) | (64'(inv) << 12) |
               (64'(edg) << 11) | (64'(foe) << 10) | (64'(ioe) << 9) | (64'(en) << 8);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [63:0] exp);
        logic [63:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic seq(input logic [15:0] v [8], input int n, input logic [15:0] idle);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_i = v[k];
        end
        @(negedge clk);
        evt_i = idle;
    endtask

    task automatic hold(input logic [15:0] v, input int n, input logic [15:0] idle);
        @(negedge clk);
        evt_i = v;
        repeat (n) @(negedge clk);
        evt_i = idle;
    endtask

    task automatic clr_all();
        evt_i = '0;
        for (int i = 0; i < NUM_CNT; i++) wr(a_cfg(i), 64'd0);
        wr(A_FRZ, 64'd0);
        wr(A_OVF, 64'hF);
    endtask

    task automatic t_reset();
        rdchk("R1 cap", A_CAP, (64'd7 << 48) | (64'(NUM_GRP-1) << 20) | (64'(CNT_W) << 8) | 64'(NUM_CNT-1));
        rdchk("R1 ovf", A_OVF, 64'd0);
        rdchk("R1 frz", A_FRZ, 64'd0);
        rdchk("R1 cnt1", a_val(1), 64'd0);
        chk("R1 irq", 64'(irq_o), 64'd0);
        rdchk("R2 cfg0 reset", a_cfg(0), 64'hFF00_0001);
        rdchk("R2 cfg1 reset", a_cfg(1), 64'd2);
        rdchk("R12 evcap0", 12'h100, 64'hFF);
        rdchk("R12 evcap1", 12'h108, (64'd1 << 32) | 64'hFF);
    endtask

    task automatic t_fixed();
        clr_all();
        wr(a_cfg(0), mk(1,0,0,0,0,0,32'h0F,5'd1) | 64'd2);
        rdchk("R2 fixed readback", a_cfg(0), mk(1,0,0,0,0,0,32'hFF,5'd0) | 64'd1);
        wr(a_val(0), 64'd0);
        hold(16'h0081, 2, 16'h0000);
        rdchk("R2 fixed counts all", a_val(0), 64'd4);
    endtask

    task automatic t_raw();
        clr_all();
        wr(a_cfg(1), mk(1,0,0,0,0,0,32'h0F,5'd1));
        wr(a_cfg(2), mk(1,0,0,0,0,0,32'hFF,5'd0));
        wr(a_val(1), 64'd0);
        wr(a_val(2), 64'd0);
        hold(16'h3FFF, 5, 16'h0000);
        rdchk("R3 masked sum grp1", a_val(1), 64'd20);
        rdchk("R3 full sum grp0", a_val(2), 64'd40);
    endtask

    task automatic t_thresh();
        clr_all();
        wr(a_cfg(1), mk(1,0,0,0,0,8'd3,32'hFF,5'd1));
        wr(a_val(1), 64'd0);
        seq('{16'h0100,16'h0700,16'h0F00,16'h0300,0,0,0,0}, 4, 16'h0000);
        rdchk("R4 threshold", a_val(1), 64'd2);
    endtask

    task automatic t_invert();
        clr_all();
        evt_i = 16'hFF00;
        wr(a_cfg(1), mk(1,0,0,0,1,8'd3,32'hFF,5'd1));
        wr(a_val(1), 64'd0);
        seq('{16'h0100,16'h0700,16'h0F00,16'h0300,0,0,0,0}, 4, 16'hFF00);
        rdchk("R5 invert", a_val(1), 64'd2);
    endtask

    task automatic t_edge();
        clr_all();
        wr(a_cfg(1), mk(1,0,0,1,0,8'd0,32'hFF,5'd1));
        wr(a_val(1), 64'd0);
        seq('{16'h0100,16'h0300,16'h0000,16'h0000,16'h0200,16'h0200,16'h0000,16'h0500}, 8, 16'h0000);
        rdchk("R6 edge", a_val(1), 64'd3);
    endtask

    task automatic t_freeze();
        clr_all();
        wr(a_cfg(1), mk(1,0,0,0,0,0,32'hFF,5'd1));
        wr(a_val(1), 64'd0);
        wr(A_FRZ, 64'h2);
        rdchk("R7 frz reg", A_FRZ, 64'h2);
        hold(16'hFF00, 4, 16'h0000);
        rdchk("R7 frozen holds", a_val(1), 64'd0);
        wr(a_val(1), 64'h1234);
        rdchk("R7 value writable", a_val(1), 64'h1234);
        wr(a_cfg(1), mk(1,0,0,0,0,8'd5,32'h3C,5'd1));
        rdchk("R7 cfg writable", a_cfg(1), mk(1,0,0,0,0,8'd5,32'h3C,5'd1) | 64'd2);
        wr(a_cfg(1), mk(1,0,0,0,0,0,32'hFF,5'd1));
        wr(A_FRZ, 64'd0);
        hold(16'h0100, 3, 16'h0000);
        rdchk("R7 resumes", a_val(1), 64'h1237);
    endtask

    task automatic t_overflow();
        clr_all();
        wr(a_cfg(3), mk(1,1,1,0,0,0,32'h07,5'd1));
        wr(a_val(3), 64'hFFFE);
        wr(a_cfg(2), mk(1,0,0,0,0,0,32'h01,5'd0));
        wr(a_val(2), 64'd0);
        hold(16'h0701, 3, 16'h0000);
        rdchk("R8 wrapped value", a_val(3), 64'd1);
        rdchk("R8 ovf bit", A_OVF, 64'h8);
        rdchk("R11 all frozen", A_FRZ, 64'hF);
        rdchk("R11 other stopped", a_val(2), 64'd1);
        chk("R10 irq set", 64'(irq_o), 64'd1);
        wr(A_OVF, 64'd0);
        rdchk("R9 zero write keeps", A_OVF, 64'h8);
        wr(A_OVF, 64'h8);
        rdchk("R9 one clears", A_OVF, 64'd0);
        chk("R10 irq cleared", 64'(irq_o), 64'd0);
        clr_all();
        wr(a_cfg(2), mk(1,0,0,0,0,0,32'h01,5'd0));
        wr(a_val(2), 64'hFFFF);
        hold(16'h0001, 1, 16'h0000);
        rdchk("R8 wrap to zero", a_val(2), 64'd0);
        rdchk("R8 ovf no ioe", A_OVF, 64'h4);
        chk("R10 no irq without enable", 64'(irq_o), 64'd0);
        rdchk("R11 no freeze without option", A_FRZ, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_raw();
        t_thresh();
        t_invert();
        t_edge();
        t_freeze();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule